// File: doc/BRIEF.md
# Synchronous Burst Read Wait Pipeline

This block decides when each data beat of a synchronous read from an external memory device is captured. A start strobe launches an access of one or more beats. The first beat needs a programmed first-access time, counted in interface clock cycles. Every later beat of the burst needs a programmed page time, counted from the capture of the beat before it. The device can stretch any beat by driving a wait input. The block samples that input on every rising clock edge while read-wait monitoring is on.

A two-bit pipeline depth sets which wait sample applies to a given cycle. At depth 0 the sample taken in that same cycle applies. At depth 1 the sample from one cycle earlier applies. At depth 2, and also at 3, the sample from two cycles earlier applies. The depth is latched at start and holds for every beat of the burst. A beat is captured only in a cycle where its access time has run out and the applied wait is inactive. If the time has run out while wait applies as active, the block enters an extension state. In that state the access timer stays frozen, the control outputs keep their levels, and no data is taken.

The controller has four states. IDLE waits for start. FIRST times the first beat. PAGE times each later beat. EXTEND holds a beat whose time is complete while wait is active. The transitions are as follows:
- IDLE→FIRST on start.
- FIRST→EXTEND and PAGE→EXTEND when the time is complete and the applied wait is active.
- FIRST, PAGE or EXTEND→PAGE on a capture that is not the last beat.
- FIRST, PAGE or EXTEND→IDLE on the capture of the last beat.

Top module: `burst_rd_wait_ctrl`

## Requirements
- R1: After reset, beat_valid_o, done_o, busy_o and stall_o are all low.
- R2: Let start be taken at the edge that ends cycle 0, and let the first-access time be T (a value of 0 counts as 1). With no wait, the first beat is captured at the edge that ends cycle T. beat_valid_o is high during cycle T+1, and beat_data_o then holds the rd_data_i value of cycle T.
- R3: Let the page time be P (0 counts as 1). With no wait, each later beat is captured P cycles after the capture of the previous beat.
- R4: If the applied wait is active in the cycle a beat's time completes, that beat is not captured. stall_o is high in every following cycle during which the beat is held. The beat is captured at the end of the first cycle whose applied wait is inactive.
- R5: The applied wait for cycle c is wait_i of cycle c at depth 0, of cycle c-1 at depth 1, and of cycle c-2 at depth 2 or 3.
- R6: Wait that applies as active only in cycles before a beat's time completes does not move that beat's capture.
- R7: The wait history is cleared when an access starts. Wait samples taken before the start, or in the start cycle itself, apply as inactive.
- R8: With wait_mon_en_i low at start, wait_i is ignored for the whole access. stall_o stays low and beats follow R2 and R3.
- R9: burst_len_i holds the beat count minus one. done_o is high only together with the last beat_valid_o. busy_o is high from the cycle after start through the cycle of the last capture, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an access when the block is idle |
| burst_len_i | input | LEN_W | Number of beats minus one |
| first_time_i | input | TIME_W | First-access time in cycles |
| page_time_i | input | TIME_W | Page/burst access time in cycles |
| wait_depth_i | input | 2 | Wait pipeline depth (0, 1, 2; 3 acts as 2) |
| wait_mon_en_i | input | 1 | Read-wait monitoring enable |
| wait_i | input | 1 | Wait input from the device, high means wait |
| rd_data_i | input | DATA_W | Read data bus from the device |
| beat_valid_o | output | 1 | One-cycle pulse after each captured beat |
| beat_data_o | output | DATA_W | Captured data of the latest beat |
| busy_o | output | 1 | Access in progress; device control asserted |
| stall_o | output | 1 | Beat extended by wait; controls held, no capture |
| done_o | output | 1 | Marks the last beat of the access |

## Verification
A corrupt wait history shows up at the ports at once. A stale or wrongly selected sample shifts the capture of the first stalled beat by one or two cycles, so beat_valid_o appears at the wrong cycle. Because rd_data_i carries the cycle number, the same beat also shows the wrong data value. A timer that loses its frozen value while a beat is extended, or a beat counter that is off by one, changes the cycle of every later beat. It also moves done_o within the same burst. A misdecoded state shows as stall_o in a cycle where wait applied as inactive, or in an access with monitoring off.

// File: rtl/burst_rd_wait_pkg.sv
package burst_rd_wait_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_PAGE   = 2'd2,
        ST_EXTEND = 2'd3
    } rdw_state_e;

    localparam int unsigned WAIT_STAGES = 2;

endpackage

// File: rtl/rdw_wait_pipe.sv
module rdw_wait_pipe
    import burst_rd_wait_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       shift_en_i,
    input  logic       mon_en_i,
    input  logic [1:0] depth_i,
    input  logic       wait_i,
    output logic       wait_eff_o
);

    logic [WAIT_STAGES-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr_i) begin
            hist_q <= '0;
        end else if (shift_en_i) begin
            hist_q[0] <= wait_i;
            for (int s = 1; s < WAIT_STAGES; s++) begin
                hist_q[s] <= hist_q[s-1];
            end
        end
    end

    logic sel_wait;
    always_comb begin
        unique case (depth_i)
            2'd0:    sel_wait = wait_i;
            2'd1:    sel_wait = hist_q[0];
            default: sel_wait = hist_q[WAIT_STAGES-1];
        endcase
    end

    assign wait_eff_o = mon_en_i & sel_wait;

    AST_HIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (hist_q == '0)); // R7

endmodule

// File: rtl/rdw_access_timer.sv
module rdw_access_timer #(
    parameter int unsigned TIME_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [TIME_W-1:0] limit_i,
    output logic              done_o
);

    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W-1:0] lim_eff;

    assign lim_eff = (limit_i == '0) ? ONE : limit_i;
    assign done_o  = (cnt_q >= lim_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ONE;
        end else if (load_i) begin
            cnt_q <= ONE;
        end else if (run_i && !done_o) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> done_o); // R4

endmodule

// File: rtl/burst_rd_wait_ctrl.sv
module burst_rd_wait_ctrl
    import burst_rd_wait_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned TIME_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic [TIME_W-1:0] first_time_i,
    input  logic [TIME_W-1:0] page_time_i,
    input  logic [1:0]        wait_depth_i,
    input  logic              wait_mon_en_i,
    input  logic              wait_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              beat_valid_o,
    output logic [DATA_W-1:0] beat_data_o,
    output logic              busy_o,
    output logic              stall_o,
    output logic              done_o
);

    rdw_state_e state_q, state_d;

    logic [LEN_W-1:0]  left_q;
    logic [TIME_W-1:0] first_q;
    logic [TIME_W-1:0] page_q;
    logic [1:0]        depth_q;
    logic              mon_q;
    logic              phase_q;

    logic accept;
    logic busy;
    logic tm_done;
    logic wait_eff;
    logic capture;
    logic last_beat;

    assign busy      = (state_q != ST_IDLE);
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign capture   = busy && tm_done && !wait_eff;
    assign last_beat = (left_q == '0);

    rdw_wait_pipe u_wait_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept),
        .shift_en_i (busy),
        .mon_en_i   (mon_q),
        .depth_i    (depth_q),
        .wait_i     (wait_i),
        .wait_eff_o (wait_eff)
    );

    rdw_access_timer #(.TIME_W(TIME_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept || capture),
        .run_i   (busy),
        .limit_i (phase_q ? page_q : first_q),
        .done_o  (tm_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FIRST;
            end
            ST_FIRST, ST_PAGE: begin
                if (capture)       state_d = last_beat ? ST_IDLE : ST_PAGE;
                else if (tm_done)  state_d = ST_EXTEND;
            end
            ST_EXTEND: begin
                if (capture)       state_d = last_beat ? ST_IDLE : ST_PAGE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            first_q <= '0;
            page_q  <= '0;
            depth_q <= '0;
            mon_q   <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                left_q  <= burst_len_i;
                first_q <= first_time_i;
                page_q  <= page_time_i;
                depth_q <= wait_depth_i;
                mon_q   <= wait_mon_en_i;
                phase_q <= 1'b0;
            end else if (capture) begin
                left_q  <= left_q - 1'b1;
                phase_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_valid_o <= 1'b0;
            beat_data_o  <= '0;
            done_o       <= 1'b0;
        end else begin
            beat_valid_o <= capture;
            done_o       <= capture && last_beat;
            if (capture) beat_data_o <= rd_data_i;
        end
    end

    assign busy_o  = busy;
    assign stall_o = (state_q == ST_EXTEND);

    AST_CAPTURE_NEEDS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> $past(tm_done)); // R2

    AST_HELD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && wait_eff) |=> (!beat_valid_o && stall_o)); // R4

    AST_MON_OFF_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_q |-> !wait_eff); // R8

    AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (beat_valid_o && !busy_o)); // R9

endmodule

// File: tb/test_burst_rd_wait_ctrl.sv
module test_burst_rd_wait_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 4;
    localparam int TIME_W = 5;
    localparam int WIN    = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  burst_len_i = '0;
    logic [TIME_W-1:0] first_time_i = '0;
    logic [TIME_W-1:0] page_time_i = '0;
    logic [1:0]        wait_depth_i = '0;
    logic              wait_mon_en_i = 1'b0;
    logic              wait_i = 1'b0;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              beat_valid_o;
    logic [DATA_W-1:0] beat_data_o;
    logic              busy_o;
    logic              stall_o;
    logic              done_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rd_wait_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TIME_W(TIME_W)) i_burst_rd_wait_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .burst_len_i   (burst_len_i),
        .first_time_i  (first_time_i),
        .page_time_i   (page_time_i),
        .wait_depth_i  (wait_depth_i),
        .wait_mon_en_i (wait_mon_en_i),
        .wait_i        (wait_i),
        .rd_data_i     (rd_data_i),
        .beat_valid_o  (beat_valid_o),
        .beat_data_o   (beat_data_o),
        .busy_o        (busy_o),
        .stall_o       (stall_o),
        .done_o        (done_o)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one access. Bit k of wmask is wait_i during cycle k (cycle 0 = start cycle).
    // ecap / estall: bit k set when beat_valid_o / stall_o is expected high in cycle k.
    task automatic run_case(input string req, input int first, input int page, input int lenm1,
                            input int depth, input logic mon, input logic [31:0] wmask,
                            input logic [31:0] ecap, input logic [31:0] estall, input int edone);
        logic [31:0] ocap = '0;
        logic [31:0] ostall = '0;
        int odone = -1;
        int bad_data = 0;
        logic busy1 = 1'b0;
        logic busy_after = 1'b1;
        @(negedge clk);
        start_i       = 1'b1;
        burst_len_i   = LEN_W'(lenm1);
        first_time_i  = TIME_W'(first);
        page_time_i   = TIME_W'(page);
        wait_depth_i  = 2'(depth);
        wait_mon_en_i = mon;
        wait_i        = wmask[0];
        rd_data_i     = '0;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (beat_valid_o) begin
                ocap[k] = 1'b1;
                if (beat_data_o != DATA_W'(k-1)) bad_data++;
            end
            if (stall_o) ostall[k] = 1'b1;
            if (done_o && odone < 0) odone = k;
            if (k == 1) busy1 = busy_o;
            if (k == edone) busy_after = busy_o;
            start_i   = 1'b0;
            wait_i    = wmask[k];
            rd_data_i = DATA_W'(k);
        end
        wait_i = 1'b0;
        check(req, "beat cycles", ocap, ecap);
        check(req, "beat data mismatches", bad_data, 0);
        check(req, "stall cycles", ostall, estall);
        check("R9", {req, " done cycle"}, odone, edone);
        check("R9", {req, " busy in cycle 1"}, busy1, 1);
        check("R9", {req, " busy after last beat"}, busy_after, 0);
    endtask

    // R2 R3 R9: four-beat burst, no wait, first time 3, page time 2
    task automatic t_plain_burst();
        run_case("R3", 3, 2, 3, 0, 1'b1, 32'h0,
                 (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 8) | (32'h1 << 10), 32'h0, 10);
    endtask

    // R4 R5: depth 0, wait active in cycles 3 and 4
    task automatic t_wait_depth0();
        run_case("R4", 3, 2, 1, 0, 1'b1, (32'h1 << 3) | (32'h1 << 4),
                 (32'h1 << 6) | (32'h1 << 8), (32'h1 << 4) | (32'h1 << 5), 8);
    endtask

    // R5: depth 1, wait sampled in cycles 2 and 3 applies to cycles 3 and 4
    task automatic t_wait_depth1();
        run_case("R5", 3, 2, 1, 1, 1'b1, (32'h1 << 2) | (32'h1 << 3),
                 (32'h1 << 6) | (32'h1 << 8), (32'h1 << 4) | (32'h1 << 5), 8);
    endtask

    // R5: depth 2, wait sampled in cycle 1 applies to cycle 3
    task automatic t_wait_depth2();
        run_case("R5", 3, 2, 0, 2, 1'b1, (32'h1 << 1),
                 (32'h1 << 5), (32'h1 << 4), 5);
    endtask

    // R8: monitoring off, wait held active throughout
    task automatic t_mon_off();
        run_case("R8", 2, 1, 2, 0, 1'b0, 32'hFFFF_FFFF,
                 (32'h1 << 3) | (32'h1 << 4) | (32'h1 << 5), 32'h0, 5);
    endtask

    // R6: wait active only before completion
    task automatic t_early_wait();
        run_case("R6", 3, 2, 0, 0, 1'b1, (32'h1 << 1) | (32'h1 << 2),
                 (32'h1 << 4), 32'h0, 4);
    endtask

    // R7: wait high while idle and in the start cycle, depth 2, first time 1
    task automatic t_history_clear();
        @(negedge clk);
        wait_i = 1'b1;
        repeat (3) @(negedge clk);
        run_case("R7", 1, 1, 0, 2, 1'b1, 32'h3, (32'h1 << 2), 32'h0, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "beat_valid_o", beat_valid_o, 0);
        check("R1", "done_o", done_o, 0);
        check("R1", "busy_o", busy_o, 0);
        check("R1", "stall_o", stall_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_plain_burst();
        t_wait_depth0();
        t_wait_depth1();
        t_wait_depth2();
        t_mon_off();
        t_early_wait();
        t_history_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule